// File: doc/BRIEF.md
# Routable Level Interrupt Aggregator

This block gathers 32 level-sensitive interrupt sources and steers each of them onto one of 15 active-high request lines headed for a processor. Every source has its own enable bit in a mask word and its own 4-bit route code. A request line is raised when at least one source is asserted, enabled and routed to that line. Software configures the block over a plain 32-bit word bus with single-cycle accesses. The bus exposes the mask word, a read-only view of the raw source levels and four routing words.

The four routing words hold eight 4-bit route codes each. They are placed in descending source order: the lowest routing address holds the top eight sources and the highest routing address holds sources 0 to 7. A route code of zero detaches a source from all lines. The request lines and the read data are registered, so both show a change one clock after it happens.

Top module: `lir_router`

## Requirements
- R1: The mask word sits at byte offset 0x00 and the routing words at 0x08, 0x0C, 0x10 and 0x14. A read issued in one cycle returns the stored value on `bus_rdata` in the following cycle, and a write takes effect at the clock edge that accepts it.
- R2: A read of offset 0x04 returns the live source levels sampled at the read's clock edge, with bit n equal to source n. Nothing is latched, so a source that has dropped reads back as 0.
- R3: The routing word at 0x08 holds sources 24–31, 0x0C holds 16–23, 0x10 holds 8–15 and 0x14 holds 0–7. Within a word, the code for source n sits in bits [4*(n mod 8)+3 : 4*(n mod 8)].
- R4: Route code 0 connects a source to no line. Code c in 1..15 connects the source to request line c-1.
- R5: A source with mask bit n at 0 never raises any request line. With the whole mask at 0, all lines are low one cycle later.
- R6: Request line k is the registered OR, over all sources, of (level high AND mask bit set AND route code equal to k+1). It reflects the inputs and register contents of the previous cycle.
- R7: Reset is asynchronous and active low. It clears the mask word, every routing code, all request lines and the read data to zero.
- R8: Writes to offset 0x04 or to any unmapped offset change no stored state. Reads of unmapped offsets return zero.
- R9: In a cycle that follows one with no read request, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_src | input | 32 | Level-sensitive sources, synchronous to clk |
| irq_out | output | 15 | Active-high request lines |

## Verification
A single source routed to the first and to the last line, placed at each end of the reversed routing layout, tells a wrong word or field placement apart from a wrong code-to-line mapping. Several enabled sources sharing one line, mixed with masked and code-0 sources on the same line, separate a correct OR from a last-writer or priority selection. Toggling the sources around status reads shows whether the status view is live or latched. A long stretch of random source levels with random mask and routing rewrites is checked against a behavioural model on every clock.

// File: rtl/lir_pkg.sv
package lir_pkg;
  localparam int SRC_N       = 32;
  localparam int OUT_N       = 15;
  localparam int CODE_W      = 4;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 8;
  localparam int FIELDS      = DATA_W / CODE_W;
  localparam int ROUTE_WORDS = SRC_N / FIELDS;
  localparam int OFF_MASK    = 'h00;
  localparam int OFF_STAT    = 'h04;
  localparam int OFF_ROUTE0  = 'h08;

  // Routing words run in descending source order.
  function automatic int first_src_of_word(int w, int fields, int words);
    return (words - 1 - w) * fields;
  endfunction

  // Code c selects line c-1; code 0 selects nothing.
  function automatic logic code_selects(logic [7:0] code, int line);
    return code == 8'(line + 1);
  endfunction

  function automatic logic is_route_addr(int addr, int words);
    return (addr >= OFF_ROUTE0) && (addr < OFF_ROUTE0 + 4 * words) && (addr % 4 == 0);
  endfunction

  function automatic int route_word_of_addr(int addr);
    return (addr - OFF_ROUTE0) / 4;
  endfunction
endpackage

// File: rtl/lir_regfile.sv
module lir_regfile
  import lir_pkg::*;
#(
  parameter int P_SRC_N  = SRC_N,
  parameter int P_CODE_W = CODE_W,
  parameter int P_DATA_W = DATA_W,
  parameter int P_ADDR_W = ADDR_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [P_ADDR_W-1:0]          addr,
  input  logic [P_DATA_W-1:0]          wdata,
  output logic [P_SRC_N-1:0]           mask_q,
  output logic [P_SRC_N*P_CODE_W-1:0]  route_q,
  output logic                         wr_mask_ev,
  output logic                         wr_drop_ev
);
  localparam int L_FIELDS = P_DATA_W / P_CODE_W;
  localparam int L_WORDS  = P_SRC_N / L_FIELDS;

  logic [L_WORDS-1:0] wr_word;

  assign wr_mask_ev = wr_en && (addr == P_ADDR_W'(OFF_MASK));
  assign wr_drop_ev = wr_en && !wr_mask_ev && (wr_word == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mask_q <= '0;
    else if (wr_mask_ev) mask_q <= wdata[P_SRC_N-1:0];
  end

  for (genvar w = 0; w < L_WORDS; w++) begin : g_word
    localparam int BASE = first_src_of_word(w, L_FIELDS, L_WORDS);
    assign wr_word[w] = wr_en && (addr == P_ADDR_W'(OFF_ROUTE0 + 4 * w));
    for (genvar j = 0; j < L_FIELDS; j++) begin : g_field
      logic [P_CODE_W-1:0] code_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          code_q <= '0;
        else if (wr_word[w]) code_q <= wdata[j*P_CODE_W +: P_CODE_W];
      end
      assign route_q[(BASE+j)*P_CODE_W +: P_CODE_W] = code_q;
    end
  end
endmodule

// File: rtl/lir_steer.sv
module lir_steer
  import lir_pkg::*;
#(
  parameter int P_SRC_N  = SRC_N,
  parameter int P_OUT_N  = OUT_N,
  parameter int P_CODE_W = CODE_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [P_SRC_N-1:0]           src,
  input  logic [P_SRC_N-1:0]           mask,
  input  logic [P_SRC_N*P_CODE_W-1:0]  route,
  output logic [P_OUT_N-1:0]           out_q
);
  logic [P_OUT_N-1:0] line_hit;

  always_comb begin
    line_hit = '0;
    for (int k = 0; k < P_OUT_N; k++) begin
      for (int n = 0; n < P_SRC_N; n++) begin
        if (src[n] && mask[n] &&
            code_selects(8'(route[n*P_CODE_W +: P_CODE_W]), k))
          line_hit[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= line_hit;
  end
endmodule

// File: rtl/lir_readback.sv
module lir_readback
  import lir_pkg::*;
#(
  parameter int P_SRC_N  = SRC_N,
  parameter int P_CODE_W = CODE_W,
  parameter int P_DATA_W = DATA_W,
  parameter int P_ADDR_W = ADDR_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [P_ADDR_W-1:0]          addr,
  input  logic [P_SRC_N-1:0]           mask,
  input  logic [P_SRC_N-1:0]           src,
  input  logic [P_SRC_N*P_CODE_W-1:0]  route,
  output logic [P_DATA_W-1:0]          rdata_q
);
  localparam int L_FIELDS = P_DATA_W / P_CODE_W;
  localparam int L_WORDS  = P_SRC_N / L_FIELDS;

  logic [P_DATA_W-1:0] word;

  always_comb begin
    int w;
    int base;
    word = '0;
    w    = route_word_of_addr(int'(addr));
    base = first_src_of_word(w, L_FIELDS, L_WORDS);
    if (addr == P_ADDR_W'(OFF_MASK)) begin
      word = P_DATA_W'(mask);
    end else if (addr == P_ADDR_W'(OFF_STAT)) begin
      word = P_DATA_W'(src);
    end else if (is_route_addr(int'(addr), L_WORDS)) begin
      for (int j = 0; j < L_FIELDS; j++)
        word[j*P_CODE_W +: P_CODE_W] = route[(base+j)*P_CODE_W +: P_CODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= word;
    else            rdata_q <= '0;
  end
endmodule

// File: rtl/lir_router.sv
module lir_router
  import lir_pkg::*;
#(
  parameter int P_SRC_N  = SRC_N,
  parameter int P_OUT_N  = OUT_N,
  parameter int P_CODE_W = CODE_W,
  parameter int P_DATA_W = DATA_W,
  parameter int P_ADDR_W = ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [P_ADDR_W-1:0]  bus_addr,
  input  logic [P_DATA_W-1:0]  bus_wdata,
  output logic [P_DATA_W-1:0]  bus_rdata,
  input  logic [P_SRC_N-1:0]   irq_src,
  output logic [P_OUT_N-1:0]   irq_out
);
  logic                        wr_en;
  logic                        rd_en;
  logic [P_SRC_N-1:0]          mask_q;
  logic [P_SRC_N*P_CODE_W-1:0] route_q;
  logic                        wr_mask_ev;
  logic                        wr_drop_ev;

  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;

  lir_regfile #(
    .P_SRC_N(P_SRC_N), .P_CODE_W(P_CODE_W), .P_DATA_W(P_DATA_W), .P_ADDR_W(P_ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata),
    .mask_q(mask_q), .route_q(route_q), .wr_mask_ev(wr_mask_ev), .wr_drop_ev(wr_drop_ev)
  );

  lir_steer #(
    .P_SRC_N(P_SRC_N), .P_OUT_N(P_OUT_N), .P_CODE_W(P_CODE_W)
  ) u_steer (
    .clk(clk), .rst_n(rst_n), .src(irq_src), .mask(mask_q), .route(route_q),
    .out_q(irq_out)
  );

  lir_readback #(
    .P_SRC_N(P_SRC_N), .P_CODE_W(P_CODE_W), .P_DATA_W(P_DATA_W), .P_ADDR_W(P_ADDR_W)
  ) u_rb (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(bus_addr), .mask(mask_q),
    .src(irq_src), .route(route_q), .rdata_q(bus_rdata)
  );
endmodule

// File: rtl/lir_router_chk.sv
module lir_router_chk #(
  parameter int P_SRC_N  = 32,
  parameter int P_OUT_N  = 15,
  parameter int P_CODE_W = 4,
  parameter int P_DATA_W = 32,
  parameter int P_ADDR_W = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_sel,
  input logic                        bus_wr,
  input logic [P_ADDR_W-1:0]         bus_addr,
  input logic [P_DATA_W-1:0]         bus_wdata,
  input logic [P_DATA_W-1:0]         bus_rdata,
  input logic [P_SRC_N-1:0]          irq_src,
  input logic [P_OUT_N-1:0]          irq_out,
  input logic [P_SRC_N-1:0]          mask_q,
  input logic [P_SRC_N*P_CODE_W-1:0] route_q,
  input logic                        wr_mask_ev,
  input logic                        wr_drop_ev
);
  assert_mask_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == '0) |=> (mask_q == $past(bus_wdata[P_SRC_N-1:0])));

  assert_mask_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask_ev |=> $stable(mask_q));

  assert_status_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == P_ADDR_W'(4)) |=> (bus_rdata == P_DATA_W'($past(irq_src))));

  assert_unrouted_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q == '0) |=> (irq_out == '0));

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> (irq_out == '0));

  assert_no_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src == '0) |=> (irq_out == '0));

  assert_drop_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop_ev |=> ($stable(mask_q) && $stable(route_q)));

  assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> (bus_rdata == '0));
endmodule

bind lir_router lir_router_chk #(
  .P_SRC_N(P_SRC_N), .P_OUT_N(P_OUT_N), .P_CODE_W(P_CODE_W),
  .P_DATA_W(P_DATA_W), .P_ADDR_W(P_ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src), .irq_out(irq_out),
  .mask_q(mask_q), .route_q(route_q), .wr_mask_ev(wr_mask_ev), .wr_drop_ev(wr_drop_ev)
);

// File: tb/test_lir_router.sv
module test_lir_router;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] irq_src;
  wire  [31:0] bus_rdata;
  wire  [14:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] m_mask;
  int          m_route [32];

  always #4 clk = ~clk;

  lir_router i_lir_router (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src), .irq_out(irq_out)
  );

  // Behavioural expectation for the request lines.
  function automatic logic [14:0] model_out(logic [31:0] s);
    logic [14:0] e = '0;
    for (int n = 0; n < 32; n++)
      if (s[n] && m_mask[n] && m_route[n] != 0) e[m_route[n]-1] = 1'b1;
    return e;
  endfunction

  // Sources for routing address a: address 0x08 holds the top eight.
  function automatic int group_base(logic [7:0] a);
    return 24 - 8 * ((int'(a) - 8) / 4);
  endfunction

  function automatic bit route_addr(logic [7:0] a);
    return a >= 8'h08 && a <= 8'h14 && a[1:0] == 2'b00;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a, logic [31:0] s);
    logic [31:0] r = '0;
    if (a == 8'h00) r = m_mask;
    else if (a == 8'h04) r = s;
    else if (route_addr(a))
      for (int j = 0; j < 8; j++) r[4*j +: 4] = 4'(m_route[group_base(a) + j]);
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit sel, bit wr, logic [7:0] a, logic [31:0] d, logic [31:0] s,
                      string otag, string rtag);
    logic [14:0] e_out;
    logic [31:0] e_rd;
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d; irq_src = s;
    e_out = model_out(s);
    e_rd  = (sel && !wr) ? model_read(a, s) : 32'h0;
    if (sel && wr) begin
      if (a == 8'h00) m_mask = d;
      else if (route_addr(a))
        for (int j = 0; j < 8; j++) m_route[group_base(a) + j] = int'(d[4*j +: 4]);
    end
    @(posedge clk);
    @(negedge clk);
    check(otag, 32'(irq_out), 32'(e_out), "irq_out");
    check(rtag, bus_rdata, e_rd, "bus_rdata");
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [31:0] s, string tag);
    step(1'b1, 1'b1, a, d, s, tag, "R9");
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] s, string tag);
    step(1'b1, 1'b0, a, 32'h0, s, "R6", tag);
  endtask

  task automatic idle(logic [31:0] s, string tag);
    step(1'b0, 1'b0, 8'h00, 32'h0, s, tag, "R9");
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    irq_src = '0;
    m_mask = '0;
    for (int n = 0; n < 32; n++) m_route[n] = 0;
    repeat (3) @(negedge clk);
    // R7: outputs low while held in reset, even with sources high
    irq_src = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R7", 32'(irq_out), 32'h0, "irq_out in reset");
    check("R7", bus_rdata, 32'h0, "bus_rdata in reset");
    rst_n = 1'b1;
    // R7: registers read back as zero after reset
    rd(8'h00, 32'hFFFF_FFFF, "R7");
    for (int a = 8; a <= 20; a += 4) rd(8'(a), 32'hFFFF_FFFF, "R7");
    idle(32'hFFFF_FFFF, "R7");

    // R1: register read-back
    wr(8'h00, 32'hA5A5_0F0F, 32'h0, "R1");
    rd(8'h00, 32'h0, "R1");
    wr(8'h0C, 32'h8765_4321, 32'h0, "R1");
    rd(8'h0C, 32'h0, "R1");

    // R3: reversed word layout and field positions
    wr(8'h00, 32'hFFFF_FFFF, 32'h0, "R3");
    wr(8'h08, 32'hF000_0000, 32'h0, "R3");     // source 31 -> line 14
    wr(8'h14, 32'h0000_0001, 32'h0, "R3");     // source 0  -> line 0
    idle(32'h8000_0000, "R3");
    idle(32'h8000_0000, "R3");
    idle(32'h0000_0001, "R3");
    idle(32'h0001_0000, "R3");                 // source 16 code 1 -> line 0
    idle(32'h0080_0000, "R3");                 // source 23 code 8 -> line 7
    rd(8'h08, 32'h0, "R3");
    rd(8'h14, 32'h0, "R3");

    // R4: code 0 detaches, every code reaches its line
    wr(8'h10, 32'h0000_0000, 32'h0, "R4");
    idle(32'h0000_FF00, "R4");
    for (int c = 0; c < 16; c++) begin
      wr(8'h10, 32'(c) << 12, 32'h0, "R4");    // source 11
      idle(32'h0000_0800, "R4");
      idle(32'h0000_0800, "R4");
    end

    // R6: several sources OR onto one line, with masked and detached ones
    wr(8'h10, 32'h3333_3333, 32'h0, "R6");     // sources 8..15 -> line 2
    wr(8'h00, 32'h0000_5500, 32'h0, "R6");
    idle(32'h0000_0100, "R6");
    idle(32'h0000_0500, "R6");
    idle(32'h0000_0200, "R6");                 // only masked one high
    idle(32'h0000_0000, "R6");

    // R5: mask blocks
    wr(8'h00, 32'h0000_0000, 32'h0000_FF00, "R5");
    idle(32'h0000_FF00, "R5");
    idle(32'hFFFF_FFFF, "R5");

    // R2: status is live
    rd(8'h04, 32'h1234_5678, "R2");
    rd(8'h04, 32'h0000_0000, "R2");
    rd(8'h04, 32'hFFFF_0001, "R2");

    // R8: ignored writes and unmapped reads
    wr(8'h00, 32'hFFFF_FFFF, 32'h0, "R8");
    wr(8'h04, 32'h0000_0000, 32'h0, "R8");
    wr(8'h18, 32'hFFFF_FFFF, 32'h0, "R8");
    wr(8'h0A, 32'h0000_0000, 32'h0, "R8");
    rd(8'h00, 32'h0, "R8");
    rd(8'h08, 32'h0, "R8");
    rd(8'h18, 32'h0, "R8");
    rd(8'hFC, 32'h0, "R8");
    idle(32'hFFFF_FFFF, "R8");

    // R6: random traffic compared every clock
    for (int i = 0; i < 3000; i++) begin
      int pick = $urandom_range(0, 9);
      logic [31:0] s = $urandom;
      if (pick == 0)      wr(8'h00, $urandom, s, "R6");
      else if (pick == 1) wr(8'(8 + 4 * $urandom_range(0, 3)), $urandom, s, "R6");
      else if (pick == 2) rd(8'(4 * $urandom_range(0, 7)), s, "R1");
      else                idle(s, "R6");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule